// File: doc/BRIEF.md
# Send DMA Descriptor Ring Writer

This block takes one packet send request and turns it into a consecutive run of 128-bit descriptors in a circular descriptor queue. A request carries a header address and a header length in dwords. It also carries up to `MAX_SEG` payload segments, each an address and a byte length, and three per-packet options: large send buffer, head-index writeback to host, and completion interrupt. The block first checks that the queue has room for the whole packet. If it has, the block writes one descriptor per cycle on a simple write port. Each descriptor carries the address split across its two words, a 2-bit ring generation, a dword count and a running buffer offset, together with first/last and option flags at fixed bit positions.

The working tail starts where the last packet ended and steps once per descriptor. When it passes the final slot it returns to slot 0, and the generation advances modulo 4. The published tail changes only once per packet, after its final descriptor has been written. At that moment an accept pulse reports the slot of the packet's first descriptor and the slot after its last, so a completion tracker can follow each request. The tracker returns retired descriptor counts on a retire port, and these reopen space. A request that does not fit is refused with a one-cycle busy pulse and leaves no trace in the queue.

Top module: `sdma_desc_writer`

## Requirements
- R1: After reset the published tail is 0, the free count is DEPTH-1, `req_ready` is 1, and `desc_we`, `acc_pulse` and `req_busy` are 0.
- R2: The first descriptor of each packet is the header descriptor. Word 0 bits 63:34 carry address bits 31:2 with bits 33:32 zero, bits 26:16 carry the header dword count, bits 10:0 are 0 and bit 12 (first) is 1. Word 1 bits 15:0 carry address bits 47:32, and its upper bits are 0.
- R3: Payload descriptor i carries segment i's address in the same layout as R2. Its dword count (bits 26:16) is its byte length rounded up to whole dwords. Its offset (bits 10:0) is the header dword count plus the dword counts of all earlier segments. Bit 12 is 0.
- R4: When the large-buffer option is requested, bit 14 is set in every descriptor of the packet; otherwise it is clear in every descriptor.
- R5: Bit 11 (last) is set only in the packet's final descriptor. Bit 13 (head writeback) and bit 15 (interrupt) are set there only, and only when requested. A packet with no segments has a single descriptor that carries both first and last.
- R6: Descriptors occupy consecutive slots. After slot DEPTH-1 comes slot 0, and the generation in word 0 bits 31:30 increments modulo 4 from that slot on. The generation is 0 after reset.
- R7: The free count equals DEPTH-1 minus (descriptors published minus descriptors retired). It drops by the packet's descriptor count in the accept cycle and rises by `ret_num` in the cycle after a retire.
- R8: A request needing more descriptors (segments + 1) than the free count gives a one-cycle `req_busy` in the next cycle. It writes no descriptor and leaves tail and free count unchanged. A request needing exactly the free count is accepted.
- R9: The published tail changes only together with `acc_pulse`. In that cycle `acc_start` is the slot of the packet's first descriptor, and `acc_next` and `tail_idx` both equal the slot after its last.
- R10: Descriptor k of an accepted request is on the write port in the (k+1)-th cycle after the accepting edge. `acc_pulse` follows in the cycle after the last descriptor, and `req_ready` is 0 while descriptors are being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Send request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_hdr_addr | input | 48 | Header physical address |
| req_hdr_dw | input | 11 | Header length in dwords |
| req_seg_cnt | input | SEGCNT_W | Number of payload segments (0..MAX_SEG) |
| req_seg_addr | input | MAX_SEG*48 | Segment addresses, segment i at bits i*48 upward |
| req_seg_bytes | input | MAX_SEG*SEG_BYTES_W | Segment byte lengths, segment i at bits i*SEG_BYTES_W upward |
| req_large | input | 1 | Use large send buffer |
| req_headwb | input | 1 | Write head index back to host after the packet |
| req_intr | input | 1 | Raise interrupt after the packet |
| req_busy | output | 1 | Request refused for lack of space |
| ret_valid | input | 1 | Retired descriptor count valid |
| ret_num | input | IDX_W+1 | Number of descriptors retired |
| desc_we | output | 1 | Descriptor write strobe |
| desc_idx | output | IDX_W | Slot being written |
| desc_w0 | output | 64 | Descriptor word 0 |
| desc_w1 | output | 64 | Descriptor word 1 |
| tail_idx | output | IDX_W | Published tail |
| free_cnt | output | IDX_W+1 | Free descriptor slots |
| acc_pulse | output | 1 | Packet fully written and published |
| acc_start | output | IDX_W | Slot of the packet's first descriptor |
| acc_next | output | IDX_W | Slot after the packet's last descriptor |

## Verification
The first edge where a request is seen decides its outcome. A refusal shows `req_busy` one cycle later. For an accepted request, descriptor k appears k+1 cycles after that edge, and the accept pulse, the new tail and the reduced free count appear one cycle after the final descriptor. A retire pulse changes the free count one cycle later. Each scenario task drives inputs on the falling edge and samples on every following falling edge in that exact cycle order. It holds its own tail, generation and outstanding-count model and compares every descriptor word against fields it assembles itself.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  localparam int DESC_ADDR_W = 48;
  localparam int DW_CNT_W    = 11;

  // word 0 bits 15..11, most significant first
  typedef struct packed {
    logic irq;
    logic big_buf;
    logic head_wb;
    logic first;
    logic last;
  } dflag_t;

  // byte length to whole dwords, rounded up
  function automatic logic [DW_CNT_W-1:0] bytes_to_dw(input logic [15:0] nbytes);
    logic [16:0] sum;
    sum = {1'b0, nbytes} + 17'd3;
    return sum[12:2];
  endfunction

  function automatic logic [63:0] make_w0(input logic [DESC_ADDR_W-1:0] addr,
                                          input logic [1:0] gen,
                                          input logic [DW_CNT_W-1:0] cnt,
                                          input dflag_t flg,
                                          input logic [DW_CNT_W-1:0] off);
    return {addr[31:2], 2'b00, gen, 3'b000, cnt, flg, off};
  endfunction

  function automatic logic [63:0] make_w1(input logic [DESC_ADDR_W-1:0] addr);
    return {48'd0, addr[47:32]};
  endfunction

endpackage

// File: rtl/sdma_ring_ptr.sv
module sdma_ring_ptr #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             publish,
  output logic [IDX_W-1:0] cur_idx,
  output logic [1:0]       cur_gen,
  output logic [IDX_W-1:0] nxt_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             wrap
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] cur_q, tail_q;
  logic [1:0]       gen_q;

  assign wrap     = step && (cur_q == LAST_SLOT);
  assign nxt_idx  = (cur_q == LAST_SLOT) ? '0 : cur_q + 1'b1;
  assign cur_idx  = cur_q;
  assign cur_gen  = gen_q;
  assign tail_idx = tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      tail_q <= '0;
      gen_q  <= 2'd0;
    end else if (step) begin
      cur_q <= nxt_idx;
      if (wrap) gen_q <= gen_q + 2'd1;
      if (publish) tail_q <= nxt_idx;
    end
  end

endmodule

// File: rtl/sdma_space.sv
module sdma_space #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           publish,
  input  logic [IDX_W:0] pub_num,
  input  logic           ret_valid,
  input  logic [IDX_W:0] ret_num,
  output logic [IDX_W:0] free_cnt
);

  logic [IDX_W:0] added_q, removed_q, outstanding;

  assign outstanding = added_q - removed_q;
  assign free_cnt    = (IDX_W+1)'(DEPTH - 1) - outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      added_q   <= '0;
      removed_q <= '0;
    end else begin
      if (publish)   added_q   <= added_q + pub_num;
      if (ret_valid) removed_q <= removed_q + ret_num;
    end
  end

endmodule

// File: rtl/sdma_desc_pack.sv
module sdma_desc_pack
  import sdma_pkg::*;
#(
  parameter int MAX_SEG     = 4,
  parameter int SEG_BYTES_W = 12,
  parameter int SEL_W       = 4
) (
  input  logic [DESC_ADDR_W-1:0]         hdr_addr,
  input  logic [DW_CNT_W-1:0]            hdr_dw,
  input  logic [MAX_SEG*DESC_ADDR_W-1:0] seg_addr,
  input  logic [MAX_SEG*SEG_BYTES_W-1:0] seg_bytes,
  input  logic [SEL_W-1:0]               sel,
  input  logic                           is_last,
  input  logic                           big_buf,
  input  logic                           head_wb,
  input  logic                           irq,
  input  logic [1:0]                     gen,
  input  logic [DW_CNT_W-1:0]            run_off,
  output logic [63:0]                    w0,
  output logic [63:0]                    w1,
  output logic [DW_CNT_W-1:0]            cur_dw
);

  logic [DESC_ADDR_W-1:0] addr_a [MAX_SEG];
  logic [DW_CNT_W-1:0]    dw_a   [MAX_SEG];

  for (genvar i = 0; i < MAX_SEG; i++) begin : g_seg
    assign addr_a[i] = seg_addr[i*DESC_ADDR_W +: DESC_ADDR_W];
    assign dw_a[i]   = bytes_to_dw(16'(seg_bytes[i*SEG_BYTES_W +: SEG_BYTES_W]));
  end

  logic [DESC_ADDR_W-1:0] pick_addr;
  logic [DW_CNT_W-1:0]    pick_dw;
  logic [DW_CNT_W-1:0]    pick_off;
  dflag_t                 flg;

  always_comb begin
    pick_addr = hdr_addr;
    pick_dw   = hdr_dw;
    pick_off  = '0;
    for (int i = 0; i < MAX_SEG; i++) begin
      if (sel == SEL_W'(i + 1)) begin
        pick_addr = addr_a[i];
        pick_dw   = dw_a[i];
        pick_off  = run_off;
      end
    end
    flg.first   = (sel == '0);
    flg.last    = is_last;
    flg.big_buf = big_buf;
    flg.head_wb = is_last && head_wb;
    flg.irq     = is_last && irq;
  end

  assign w0     = make_w0(pick_addr, gen, pick_dw, flg, pick_off);
  assign w1     = make_w1(pick_addr);
  assign cur_dw = pick_dw;

endmodule

// File: rtl/sdma_desc_writer.sv
module sdma_desc_writer
  import sdma_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int MAX_SEG     = 4,
  parameter int SEG_BYTES_W = 12,
  localparam int IDX_W      = $clog2(DEPTH),
  localparam int SEGCNT_W   = $clog2(MAX_SEG + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [DESC_ADDR_W-1:0]         req_hdr_addr,
  input  logic [DW_CNT_W-1:0]            req_hdr_dw,
  input  logic [SEGCNT_W-1:0]            req_seg_cnt,
  input  logic [MAX_SEG*DESC_ADDR_W-1:0] req_seg_addr,
  input  logic [MAX_SEG*SEG_BYTES_W-1:0] req_seg_bytes,
  input  logic                           req_large,
  input  logic                           req_headwb,
  input  logic                           req_intr,
  output logic                           req_busy,
  input  logic                           ret_valid,
  input  logic [IDX_W:0]                 ret_num,
  output logic                           desc_we,
  output logic [IDX_W-1:0]               desc_idx,
  output logic [63:0]                    desc_w0,
  output logic [63:0]                    desc_w1,
  output logic [IDX_W-1:0]               tail_idx,
  output logic [IDX_W:0]                 free_cnt,
  output logic                           acc_pulse,
  output logic [IDX_W-1:0]               acc_start,
  output logic [IDX_W-1:0]               acc_next
);

  localparam int NEED_W = SEGCNT_W + 1;

  // request latch
  logic                           emitting_q;
  logic [DESC_ADDR_W-1:0]         hdr_addr_q;
  logic [DW_CNT_W-1:0]            hdr_dw_q;
  logic [MAX_SEG*DESC_ADDR_W-1:0] seg_addr_q;
  logic [MAX_SEG*SEG_BYTES_W-1:0] seg_bytes_q;
  logic                           large_q, headwb_q, intr_q;
  logic [NEED_W-1:0]              n_q, k_q;
  logic [DW_CNT_W-1:0]            off_q;
  logic [IDX_W-1:0]               start_q, acc_next_q;
  logic                           busy_q, acc_q;

  // named internal events
  logic [SEGCNT_W-1:0] seg_cnt_eff;
  logic [NEED_W-1:0]   need;
  logic                fits, accept, refuse, emit_last;
  logic                ring_wrap;

  logic [IDX_W-1:0]    cur_idx, nxt_idx;
  logic [1:0]          cur_gen;
  logic [DW_CNT_W-1:0] cur_dw;

  assign seg_cnt_eff = (req_seg_cnt > SEGCNT_W'(MAX_SEG)) ? SEGCNT_W'(MAX_SEG) : req_seg_cnt;
  assign need        = {1'b0, seg_cnt_eff} + NEED_W'(1);
  assign fits        = (IDX_W+1)'(need) <= free_cnt;
  assign req_ready   = !emitting_q;
  assign accept      = req_valid && req_ready && fits;
  assign refuse      = req_valid && req_ready && !fits;
  assign emit_last   = emitting_q && (k_q == n_q - NEED_W'(1));

  sdma_ring_ptr #(.DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (emitting_q),
    .publish  (emit_last),
    .cur_idx  (cur_idx),
    .cur_gen  (cur_gen),
    .nxt_idx  (nxt_idx),
    .tail_idx (tail_idx),
    .wrap     (ring_wrap)
  );

  sdma_space #(.DEPTH(DEPTH)) u_space (
    .clk       (clk),
    .rst_n     (rst_n),
    .publish   (emit_last),
    .pub_num   ((IDX_W+1)'(n_q)),
    .ret_valid (ret_valid),
    .ret_num   (ret_num),
    .free_cnt  (free_cnt)
  );

  sdma_desc_pack #(
    .MAX_SEG     (MAX_SEG),
    .SEG_BYTES_W (SEG_BYTES_W),
    .SEL_W       (NEED_W)
  ) u_pack (
    .hdr_addr  (hdr_addr_q),
    .hdr_dw    (hdr_dw_q),
    .seg_addr  (seg_addr_q),
    .seg_bytes (seg_bytes_q),
    .sel       (k_q),
    .is_last   (emit_last),
    .big_buf   (large_q),
    .head_wb   (headwb_q),
    .irq       (intr_q),
    .gen       (cur_gen),
    .run_off   (off_q),
    .w0        (desc_w0),
    .w1        (desc_w1),
    .cur_dw    (cur_dw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emitting_q  <= 1'b0;
      hdr_addr_q  <= '0;
      hdr_dw_q    <= '0;
      seg_addr_q  <= '0;
      seg_bytes_q <= '0;
      large_q     <= 1'b0;
      headwb_q    <= 1'b0;
      intr_q      <= 1'b0;
      n_q         <= '0;
      k_q         <= '0;
      off_q       <= '0;
      start_q     <= '0;
      acc_next_q  <= '0;
      busy_q      <= 1'b0;
      acc_q       <= 1'b0;
    end else begin
      busy_q <= refuse;
      acc_q  <= emit_last;
      if (accept) begin
        emitting_q  <= 1'b1;
        hdr_addr_q  <= req_hdr_addr;
        hdr_dw_q    <= req_hdr_dw;
        seg_addr_q  <= req_seg_addr;
        seg_bytes_q <= req_seg_bytes;
        large_q     <= req_large;
        headwb_q    <= req_headwb;
        intr_q      <= req_intr;
        n_q         <= need;
        k_q         <= '0;
        off_q       <= req_hdr_dw;
        start_q     <= cur_idx;
      end else if (emitting_q) begin
        k_q <= k_q + NEED_W'(1);
        if (k_q != '0) off_q <= off_q + cur_dw;
        if (emit_last) begin
          emitting_q <= 1'b0;
          acc_next_q <= nxt_idx;
        end
      end
    end
  end

  assign desc_we   = emitting_q;
  assign desc_idx  = cur_idx;
  assign req_busy  = busy_q;
  assign acc_pulse = acc_q;
  assign acc_start = start_q;
  assign acc_next  = acc_next_q;

endmodule

// File: rtl/sdma_desc_writer_chk.sv
module sdma_desc_writer_chk #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             req_busy,
  input logic             desc_we,
  input logic [IDX_W-1:0] desc_idx,
  input logic [63:0]      desc_w0,
  input logic [IDX_W-1:0] tail_idx,
  input logic [IDX_W:0]   free_cnt,
  input logic             acc_pulse,
  input logic [IDX_W-1:0] acc_next,
  input logic             ring_wrap
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(DEPTH - 1);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_busy |-> !desc_we);

  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> !req_ready);

  // R9
  tail_on_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_idx != $past(tail_idx)) |-> acc_pulse);

  // R9
  acc_tail_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> (acc_next == tail_idx));

  // R5
  last_then_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_w0[11]) |=> (!desc_we && acc_pulse));

  // R2
  first_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && desc_w0[12]) |-> (desc_w0[10:0] == 11'd0));

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && $past(desc_we) && $past(desc_idx) != LAST_SLOT)
      |-> (desc_idx == $past(desc_idx) + 1'b1));

  // R6
  gen_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we && $past(ring_wrap))
      |-> (desc_idx == '0 && desc_w0[31:30] == $past(desc_w0[31:30]) + 2'd1));

  // R7
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= (IDX_W+1)'(DEPTH - 1));

endmodule

bind sdma_desc_writer sdma_desc_writer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .req_busy  (req_busy),
  .desc_we   (desc_we),
  .desc_idx  (desc_idx),
  .desc_w0   (desc_w0),
  .tail_idx  (tail_idx),
  .free_cnt  (free_cnt),
  .acc_pulse (acc_pulse),
  .acc_next  (acc_next),
  .ring_wrap (ring_wrap)
);

// File: tb/test_sdma_desc_writer.sv
module test_sdma_desc_writer;

  localparam int DEPTH = 256;
  localparam int NSEG  = 4;
  localparam int BW    = 12;
  localparam int IW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [47:0]          req_hdr_addr = '0;
  logic [10:0]          req_hdr_dw = '0;
  logic [2:0]           req_seg_cnt = '0;
  logic [NSEG*48-1:0]   req_seg_addr = '0;
  logic [NSEG*BW-1:0]   req_seg_bytes = '0;
  logic                 req_large = 1'b0;
  logic                 req_headwb = 1'b0;
  logic                 req_intr = 1'b0;
  logic                 req_busy;
  logic                 ret_valid = 1'b0;
  logic [IW:0]          ret_num = '0;
  logic                 desc_we;
  logic [IW-1:0]        desc_idx;
  logic [63:0]          desc_w0, desc_w1;
  logic [IW-1:0]        tail_idx;
  logic [IW:0]          free_cnt;
  logic                 acc_pulse;
  logic [IW-1:0]        acc_start, acc_next;

  sdma_desc_writer #(.DEPTH(DEPTH), .MAX_SEG(NSEG), .SEG_BYTES_W(BW)) i_sdma_desc_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_hdr_addr(req_hdr_addr), .req_hdr_dw(req_hdr_dw), .req_seg_cnt(req_seg_cnt),
    .req_seg_addr(req_seg_addr), .req_seg_bytes(req_seg_bytes), .req_large(req_large),
    .req_headwb(req_headwb), .req_intr(req_intr), .req_busy(req_busy),
    .ret_valid(ret_valid), .ret_num(ret_num), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_w0(desc_w0), .desc_w1(desc_w1), .tail_idx(tail_idx), .free_cnt(free_cnt),
    .acc_pulse(acc_pulse), .acc_start(acc_start), .acc_next(acc_next)
  );

  int total = 0;
  int bad = 0;
  int m_tail = 0;
  int m_gen = 0;
  int m_out = 0;
  logic [47:0] sa [NSEG];
  int          sb [NSEG];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_w0(input logic [47:0] a, input int gen, input int cnt,
                                         input int off, input bit irq, input bit big,
                                         input bit hw, input bit first, input bit last);
    logic [63:0] r;
    r = {32'd0, a[31:0] & 32'hFFFF_FFFC} << 32;
    r = r + (64'(gen) << 30) + (64'(cnt) << 16) + 64'(off);
    r = r + (64'(irq) << 15) + (64'(big) << 14) + (64'(hw) << 13) + (64'(first) << 12) + (64'(last) << 11);
    return r;
  endfunction

  // send one packet; checks busy or every descriptor, then the publish cycle
  task automatic send_pkt(input logic [47:0] ha, input int hdw, input int ns,
                          input bit big, input bit hw, input bit irq);
    int  need, off, start, cnt;
    bit  busy_exp, last;
    logic [47:0] a;
    need = ns + 1;
    busy_exp = need > (DEPTH - 1 - m_out);
    @(negedge clk);
    req_valid = 1'b1; req_hdr_addr = ha; req_hdr_dw = 11'(hdw); req_seg_cnt = 3'(ns);
    for (int i = 0; i < NSEG; i++) begin
      req_seg_addr[i*48 +: 48] = sa[i];
      req_seg_bytes[i*BW +: BW] = BW'(sb[i]);
    end
    req_large = big; req_headwb = hw; req_intr = irq;
    @(negedge clk);
    req_valid = 1'b0;
    if (busy_exp) begin
      chk(req_busy == 1'b1, "R8 busy pulse", 64'(req_busy), 64'd1);
      chk(desc_we == 1'b0, "R8 no write when refused", 64'(desc_we), 64'd0);
      chk(tail_idx == IW'(m_tail), "R8 tail kept", 64'(tail_idx), 64'(m_tail));
      @(negedge clk);
      chk(req_busy == 1'b0, "R8 busy one cycle", 64'(req_busy), 64'd0);
      chk(desc_we == 1'b0, "R8 still no write", 64'(desc_we), 64'd0);
      chk(free_cnt == (IW+1)'(DEPTH - 1 - m_out), "R8 free kept", 64'(free_cnt), 64'(DEPTH - 1 - m_out));
      return;
    end
    start = m_tail;
    off = hdw;
    for (int k = 0; k < need; k++) begin
      last = (k == need - 1);
      if (k == 0) begin a = ha; cnt = hdw; end
      else begin a = sa[k-1]; cnt = (sb[k-1] + 3) / 4; end
      chk(desc_we == 1'b1, "R10 descriptor strobe", 64'(desc_we), 64'd1);
      chk(req_ready == 1'b0, "R10 ready low while writing", 64'(req_ready), 64'd0);
      chk(desc_idx == IW'(m_tail), "R6 slot", 64'(desc_idx), 64'(m_tail));
      chk(desc_w0 == exp_w0(a, m_gen, cnt, (k == 0) ? 0 : off, last && irq, big, last && hw, k == 0, last),
          (k == 0) ? "R2 R4 R5 header word0" : "R3 R4 R5 R6 payload word0",
          desc_w0, exp_w0(a, m_gen, cnt, (k == 0) ? 0 : off, last && irq, big, last && hw, k == 0, last));
      chk(desc_w1 == {48'd0, a[47:32]}, "R2 R3 word1", desc_w1, {48'd0, a[47:32]});
      if (k != 0) off = off + cnt;
      if (m_tail == DEPTH - 1) begin m_tail = 0; m_gen = (m_gen + 1) % 4; end
      else m_tail = m_tail + 1;
      @(negedge clk);
    end
    m_out = m_out + need;
    chk(desc_we == 1'b0, "R5 nothing after last", 64'(desc_we), 64'd0);
    chk(acc_pulse == 1'b1, "R9 accept pulse", 64'(acc_pulse), 64'd1);
    chk(acc_start == IW'(start), "R9 accept start", 64'(acc_start), 64'(start));
    chk(acc_next == IW'(m_tail), "R9 accept next", 64'(acc_next), 64'(m_tail));
    chk(tail_idx == IW'(m_tail), "R9 tail published", 64'(tail_idx), 64'(m_tail));
    chk(free_cnt == (IW+1)'(DEPTH - 1 - m_out), "R7 free after publish", 64'(free_cnt), 64'(DEPTH - 1 - m_out));
  endtask

  task automatic retire(input int n);
    @(negedge clk);
    ret_valid = 1'b1; ret_num = (IW+1)'(n);
    @(negedge clk);
    ret_valid = 1'b0;
    m_out = m_out - n;
    chk(free_cnt == (IW+1)'(DEPTH - 1 - m_out), "R7 free after retire", 64'(free_cnt), 64'(DEPTH - 1 - m_out));
  endtask

  task automatic t_reset();
    chk(tail_idx == '0, "R1 tail", 64'(tail_idx), 64'd0);
    chk(free_cnt == (IW+1)'(DEPTH - 1), "R1 free", 64'(free_cnt), 64'(DEPTH - 1));
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(!desc_we && !acc_pulse && !req_busy, "R1 idle strobes", {61'd0, desc_we, acc_pulse, req_busy}, 64'd0);
  endtask

  task automatic t_header_only();
    send_pkt(48'hABCD_1234_5677, 9, 0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_segments();
    sa[0] = 48'h0001_0000_1003; sb[0] = 16;
    sa[1] = 48'h7FFF_8000_0202; sb[1] = 10;
    sa[2] = 48'h0000_F000_0040; sb[2] = 4;
    send_pkt(48'h1111_2222_3330, 6, 3, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_fill_and_refuse();
    for (int p = 0; p < 50; p++) begin
      for (int i = 0; i < NSEG; i++) begin
        sa[i] = 48'(p * 4096 + i * 64 + 8);
        sb[i] = 1 + ((p * 7 + i * 13) % 200);
      end
      send_pkt(48'(p * 256), 5 + p % 3, 4, p[0], p[1], p[2]);
    end
    chk(free_cnt == '0, "R7 full queue", 64'(free_cnt), 64'd0);
    send_pkt(48'h55, 2, 0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_wrap();
    retire(m_out);
    sa[0] = 48'h10; sb[0] = 8; sa[1] = 48'h20; sb[1] = 3; sa[2] = 48'h30; sb[2] = 5;
    send_pkt(48'h4000, 4, 3, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_gen_cycle();
    for (int p = 0; p < 154; p++) begin
      for (int i = 0; i < NSEG; i++) begin
        sa[i] = 48'(p * 32 + i);
        sb[i] = 4 * (i + 1) + p % 4;
      end
      send_pkt(48'(p * 1024 + 12), 3, 4, 1'b1, 1'b0, p[0]);
      retire(5);
    end
    chk(m_gen == 0, "R6 generation back to 0", 64'(m_gen), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < NSEG; i++) begin sa[i] = '0; sb[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_header_only();
    t_segments();
    t_fill_and_refuse();
    t_wrap();
    t_gen_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule